// File: doc/BRIEF.md
# 16-bit Shift and Rotate Unit

A purely combinational unit that moves a 16-bit data word left or right by a count taken from a second 16-bit word. One mode bit selects whether bits that leave one end are dropped with zero fill (logical shift) or re-enter at the other end (rotate). A second bit selects the direction. The output settles in the same cycle the inputs change, so the unit can sit inside a datapath stage of a small processor or a bit-manipulation engine.

Every count value has a defined result. In shift mode, a count of 16 or more clears the word. In rotate mode, only the low four bits of the count are used, so the count wraps modulo 16. Internally the word passes through four conditional stages of 1, 2, 4 and 8 positions. Right moves are done by bit-reversing the word before and after a left network.

Top module: `shift_rotate16`

## Requirements
- R1: With `rot_sel`=0 and `dir_right`=0, `dout` equals `din` shifted left by `amt` positions (for `amt` below 16), and the vacated low bits are 0.
- R2: With `rot_sel`=0 and `dir_right`=1, `dout` equals `din` shifted right by `amt` positions (for `amt` below 16), and the vacated high bits are 0.
- R3: With `rot_sel`=1 and `dir_right`=0, `dout` is `din` rotated left by `amt` modulo 16. Bits that leave at bit 15 re-enter at bit 0.
- R4: With `rot_sel`=1 and `dir_right`=1, `dout` is `din` rotated right by `amt` modulo 16.
- R5: In shift mode, any `amt` of 16 or more gives `dout` = 0x0000 in both directions.
- R6: `amt` = 0 gives `dout` = `din` in all four modes.
- R7: In rotate mode, `amt` bits 15:4 have no effect. Any `amt` whose bits 3:0 are zero (for example 16 or 0xFFF0) returns `din` unchanged.
- R8: A rotate never changes the number of set bits, and a shift never increases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 16 | Data word to be moved |
| amt | input | 16 | Position count, unsigned |
| rot_sel | input | 1 | 0 = logical shift, 1 = rotate |
| dir_right | input | 1 | 0 = toward bit 15, 1 = toward bit 0 |
| dout | output | 16 | Result word |

## Verification
The unit holds no state, so a wrong stage or a wrong select shows on `dout` in the same cycle as the stimulus. A faulty stage shows up only for counts that have that stage's bit set. For this reason the counts are swept across every value from 0 to 20, plus large words, in all four modes. This sweep exposes a stuck stage, a missing wrap, a wrong direction reversal or an overflow test on the wrong bits. The operand patterns are asymmetric, so a mirrored or mis-filled result cannot pass by coincidence.

// File: rtl/shift_rotate16.sv
module shift_rotate16 #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] amt,
  input  logic         rot_sel,
  input  logic         dir_right,
  output logic [W-1:0] dout
);
  localparam int SW = $clog2(W);

  logic [W-1:0] pre, post;
  logic [W-1:0] stg [0:SW];
  logic         big;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign pre[i]  = dir_right ? din[W-1-i] : din[i];
    assign post[i] = dir_right ? stg[SW][W-1-i] : stg[SW][i];
  end

  assign stg[0] = pre;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [D-1:0] wrap;
    assign wrap       = rot_sel ? stg[s][W-1 -: D] : '0;
    assign stg[s+1]   = amt[s] ? {stg[s][W-1-D:0], wrap} : stg[s];
  end

  assign big  = |amt[W-1:SW];
  assign dout = (!rot_sel && big) ? '0 : post;

  always_comb begin
    if (amt == '0)
      assert_zero_pass_R6: assert (dout == din);
    if (rot_sel && amt[SW-1:0] == '0)
      assert_rot_wrap_R7: assert (dout == din);
    if (!rot_sel && amt >= W)
      assert_shift_clear_R5: assert (dout == '0);
    if (rot_sel)
      assert_rot_ones_R8: assert ($countones(dout) == $countones(din));
    else
      assert_shift_ones_R8: assert ($countones(dout) <= $countones(din));
    if (!rot_sel && !dir_right && amt < W && amt != '0)
      assert_left_fill_R1: assert (dout[0] == 1'b0);
    if (!rot_sel && dir_right && amt < W && amt != '0)
      assert_right_fill_R2: assert (dout[W-1] == 1'b0);
  end
endmodule

// File: tb/test_shift_rotate16.sv
module test_shift_rotate16;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [15:0] din, amt, dout;
  logic rot_sel, dir_right;
  int total = 0, bad = 0;
  bit done = 0;

  shift_rotate16 i_shift_rotate16 (
    .din(din), .amt(amt), .rot_sel(rot_sel), .dir_right(dir_right), .dout(dout)
  );

  typedef struct packed {
    logic [15:0] d; logic [15:0] a; logic r; logic dr; logic [15:0] e; logic [7:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'd4,     1'b0, 1'b0, 16'h2340, 8'd1},  // R1
    '{16'h1234, 16'd4,     1'b0, 1'b1, 16'h0123, 8'd2},  // R2
    '{16'h1234, 16'd4,     1'b1, 1'b0, 16'h2341, 8'd3},  // R3
    '{16'h1234, 16'd4,     1'b1, 1'b1, 16'h4123, 8'd4},  // R4
    '{16'h8001, 16'd1,     1'b0, 1'b0, 16'h0002, 8'd1},  // R1
    '{16'h8001, 16'd1,     1'b1, 1'b0, 16'h0003, 8'd3},  // R3
    '{16'h8001, 16'd1,     1'b0, 1'b1, 16'h4000, 8'd2},  // R2
    '{16'h8001, 16'd1,     1'b1, 1'b1, 16'hC000, 8'd4},  // R4
    '{16'hABCD, 16'd8,     1'b1, 1'b0, 16'hCDAB, 8'd3},  // R3
    '{16'hFFFF, 16'd15,    1'b0, 1'b0, 16'h8000, 8'd1},  // R1
    '{16'hFFFF, 16'd15,    1'b0, 1'b1, 16'h0001, 8'd2},  // R2
    '{16'hABCD, 16'd16,    1'b0, 1'b0, 16'h0000, 8'd5},  // R5
    '{16'hABCD, 16'h0100,  1'b0, 1'b1, 16'h0000, 8'd5},  // R5
    '{16'hABCD, 16'h0010,  1'b1, 1'b1, 16'hABCD, 8'd7},  // R7
    '{16'hABCD, 16'h0014,  1'b1, 1'b0, 16'hBCDA, 8'd7},  // R7
    '{16'hABCD, 16'h0000,  1'b0, 1'b1, 16'hABCD, 8'd6}   // R6
  };

  function automatic logic [15:0] model(logic [15:0] d, logic [15:0] a, logic r, logic dr);
    logic [15:0] v = d;
    int n = r ? int'(a[3:0]) : int'(a);
    if (!r && n >= 16) return 16'h0000;
    for (int k = 0; k < n; k++) begin
      if (!dr) v = {v[14:0], r ? v[15] : 1'b0};
      else     v = {r ? v[0] : 1'b0, v[15:1]};
    end
    return v;
  endfunction

  task automatic apply(input logic [15:0] d, input logic [15:0] a, input logic r,
                       input logic dr, input logic [15:0] e, input int req);
    @(posedge clk);
    din = d; amt = a; rot_sel = r; dir_right = dr;
    @(negedge clk);
    total++;
    if (dout !== e) begin
      bad++;
      $display("FAIL R%0d din=%h amt=%h rot=%b right=%b actual=%h expected=%h",
               req, d, a, r, dr, dout, e);
    end
  endtask

  initial begin
    din = 0; amt = 0; rot_sel = 0; dir_right = 0;
    // initial state: all-zero inputs give zero (R6, R8)
    apply(16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 6);
    for (int i = 0; i < NV; i++)
      apply(VEC[i].d, VEC[i].a, VEC[i].r, VEC[i].dr, VEC[i].e, int'(VEC[i].req));
    for (int m = 0; m < 4; m++) begin
      logic r = m[1], dr = m[0];
      int req = r ? (dr ? 4 : 3) : (dr ? 2 : 1);  // R1 R2 R3 R4 sweep
      for (int a = 0; a <= 20; a++)
        apply(16'h9D3B, 16'(a), r, dr, model(16'h9D3B, 16'(a), r, dr),
              (a == 0) ? 6 : (a >= 16 ? (r ? 7 : 5) : req));
      // R5 / R7 with all count bits set
      apply(16'h9D3B, 16'hFFFF, r, dr, model(16'h9D3B, 16'hFFFF, r, dr), r ? 7 : 5);
      apply(16'h9D3B, 16'hFFF0, r, dr, r ? 16'h9D3B : 16'h0000, r ? 7 : 5);
      // R8 zero operand stays zero
      apply(16'h0000, 16'd7, r, dr, 16'h0000, 8);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule